// File: doc/BRIEF.md
# Single-Cycle 17x17 Multiply-Accumulate Lane

This block is one multiply-accumulate lane of a fixed-point DSP datapath. Each accepted cycle, it multiplies two 17-bit signed operands and adds the product to a 40-bit accumulator value, or subtracts it. The result is registered one clock later. The multiplier is a radix-4 Booth recoder. Its partial products carry a flipped sign bit, and one constant row stands in for full sign extension. A tree of 4:2 and 3:2 compressors reduces the rows before a single carry-propagate add.

Mode inputs set the operation for each operand set:
- integer or fractional (doubled) product;
- add or subtract;
- optional round to bit 16;
- optional clamping;
- overflow judged at a 32-bit or a 40-bit width.

An overflow flag registers alongside the result. It reports whether the exact result left the range of the selected width, whether or not clamping was enabled.

Top module: `mac17_lane`

## Requirements
- R1: While `rst_n` is low, `result` is 0, `ovf` is 0 and `out_valid` is 0.
- R2: With `in_valid` high at a rising edge, `out_valid` is high after that edge, and `result` holds `acc_in + op_a*op_b`. With `sub_en`=1 it holds `acc_in - op_a*op_b`. All values are signed two's complement.
- R3: With `frac_en`=1, the product is doubled before it is accumulated.
- R4: With `frac_en`=1 and both operands equal to 17'h18000 (-32768), the product used is 0x7FFF_FFFF instead of 2^31.
- R5: With `rnd_en`=1, 0x8000 is added to the exact accumulated value and bits 15:0 are then cleared. This happens before the overflow check and clamping.
- R6: With `sat32`=1, `ovf` is set when the value after R5 lies outside [-2^31, 2^31-1]. If `sat_en`=1 as well, `result` is clamped to 0x00_7FFF_FFFF or 0xFF_8000_0000.
- R7: With `sat32`=0, `ovf` is set when the value lies outside the signed 40-bit range. If `sat_en`=1, `result` is clamped to 0x7F_FFFF_FFFF or 0x80_0000_0000.
- R8: With `sat_en`=0, `result` is the low 40 bits of the value after R5. `ovf` still reports overflow of the selected width.
- R9: In a cycle with `in_valid` low, `result` and `ovf` keep their values and `out_valid` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set is present this cycle |
| op_a | input | 17 | Signed multiplicand |
| op_b | input | 17 | Signed multiplier (Booth recoded) |
| acc_in | input | 40 | Signed accumulator operand |
| frac_en | input | 1 | Fractional mode: product doubled |
| sub_en | input | 1 | Subtract product instead of adding |
| rnd_en | input | 1 | Round to bit 16 |
| sat_en | input | 1 | Clamp on overflow |
| sat32 | input | 1 | 1: 32-bit limits, 0: 40-bit limits |
| result | output | 40 | Registered accumulated value |
| ovf | output | 1 | Registered overflow of the selected width |
| out_valid | output | 1 | Result updated on the last edge |

## Verification
Rounding and saturation can both act on one result. A value just below the positive 32-bit limit can be pushed over it by the rounding increment, and it must then clamp instead of wrapping. The bench sets accumulators a few counts under 2^31-1 and under 2^39-1, with rounding and clamping enabled together. It also sends random vectors that mix all mode bits. It judges each result against a 64-bit reference that rounds first and then tests the limits. The fractional special case is also tried with subtraction and rounding active, so the substituted product travels through the rest of the path.

// File: rtl/mac17_lane.sv
module mac17_lane #(
  parameter int ACC_W   = 40,
  parameter int NARROW  = 32,
  parameter int RND_BIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [16:0]      op_a,
  input  logic [16:0]      op_b,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             frac_en,
  input  logic             sub_en,
  input  logic             rnd_en,
  input  logic             sat_en,
  input  logic             sat32,
  output logic [ACC_W-1:0] result,
  output logic             ovf,
  output logic             out_valid
);
  localparam int OPW  = 17;
  localparam int MW   = OPW + 1;
  localparam int NG   = MW / 2;
  localparam int NR   = NG + 2;
  localparam int PW   = 2 * OPW;
  localparam int TW   = PW + 2;
  localparam int XW   = ACC_W + 2;
  localparam logic [OPW-1:0] NEG_HALF = {2'b11, {(OPW-2){1'b0}}};

  function automatic logic [TW-1:0] sign_fix();
    logic [TW-1:0] k = '0;
    for (int i = 0; i < NG; i++) k = k - (TW'(1) << (MW - 1 + 2 * i));
    return k;
  endfunction
  localparam logic [TW-1:0] KROW = sign_fix();

  function automatic logic [2*TW-1:0] c32(input logic [TW-1:0] x, y, z);
    return {x ^ y ^ z, ((x & y) | (x & z) | (y & z)) << 1};
  endfunction

  function automatic logic [2*TW-1:0] c42(input logic [TW-1:0] x, y, z, w);
    logic [2*TW-1:0] f;
    f = c32(x, y, z);
    return c32(f[2*TW-1:TW], f[TW-1:0], w);
  endfunction

  logic [MW:0]   b_ext;
  logic [MW-1:0] a_ext;
  logic [TW-1:0] rows [NR];
  logic [TW-1:0] neg_row;

  assign b_ext = {op_b[OPW-1], op_b, 1'b0};
  assign a_ext = {op_a[OPW-1], op_a};

  for (genvar i = 0; i < NG; i++) begin : g_booth
    logic [2:0]    grp;
    logic          one, two, neg;
    logic [MW-1:0] mag, x;
    assign grp = b_ext[2*i+2:2*i];
    assign one = grp[1] ^ grp[0];
    assign two = (grp == 3'b100) || (grp == 3'b011);
    assign neg = grp[2];
    assign mag = one ? a_ext : two ? {op_a, 1'b0} : '0;
    assign x   = mag ^ {MW{neg}};
    assign rows[i] = TW'({~x[MW-1], x[MW-2:0]}) << (2 * i);
    assign neg_row[2*i]   = neg;
    assign neg_row[2*i+1] = 1'b0;
  end
  assign neg_row[TW-1:2*NG] = '0;
  assign rows[NG]   = neg_row;
  assign rows[NG+1] = KROW;

  logic [2*TW-1:0] l1a, l1b, l1c, l2, l3;
  logic [TW-1:0]   prod_t;
  assign l1a = c42(rows[0], rows[1], rows[2], rows[3]);
  assign l1b = c42(rows[4], rows[5], rows[6], rows[7]);
  assign l1c = c32(rows[8], rows[9], rows[10]);
  assign l2  = c42(l1a[2*TW-1:TW], l1a[TW-1:0], l1b[2*TW-1:TW], l1b[TW-1:0]);
  assign l3  = c42(l2[2*TW-1:TW], l2[TW-1:0], l1c[2*TW-1:TW], l1c[TW-1:0]);
  assign prod_t = l3[2*TW-1:TW] + l3[TW-1:0];

  logic          special;
  logic [XW-1:0] prod_x, pm, acc_x, sum, rsum;
  logic          ovf_n, ovf_w, ovf_sel;
  logic [ACC_W-1:0] nxt;

  assign special = frac_en && (op_a == NEG_HALF) && (op_b == NEG_HALF);
  assign prod_x  = XW'(signed'(prod_t[PW-1:0]));
  assign pm      = special ? XW'({1'b0, {(NARROW-1){1'b1}}})
                 : frac_en ? (prod_x << 1) : prod_x;
  assign acc_x   = XW'(signed'(acc_in));
  assign sum     = sub_en ? acc_x - pm : acc_x + pm;
  assign rsum    = rnd_en ? ((sum + (XW'(1) << (RND_BIT - 1))) & ~((XW'(1) << RND_BIT) - 1)) : sum;

  assign ovf_n   = !((&rsum[XW-1:NARROW-1]) || !(|rsum[XW-1:NARROW-1]));
  assign ovf_w   = !((&rsum[XW-1:ACC_W-1]) || !(|rsum[XW-1:ACC_W-1]));
  assign ovf_sel = sat32 ? ovf_n : ovf_w;

  always_comb begin
    nxt = rsum[ACC_W-1:0];
    if (sat_en && ovf_sel) begin
      if (sat32) nxt = rsum[XW-1] ? ~ACC_W'((ACC_W'(1) << (NARROW - 1)) - 1)
                                  : ACC_W'((ACC_W'(1) << (NARROW - 1)) - 1);
      else       nxt = rsum[XW-1] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      ovf       <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt;
        ovf    <= ovf_sel;
      end
    end
  end
endmodule

module mac17_lane_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [16:0] op_a,
  input logic [16:0] op_b,
  input logic [39:0] acc_in,
  input logic        frac_en,
  input logic        sub_en,
  input logic        rnd_en,
  input logic        sat_en,
  input logic        sat32,
  input logic [39:0] result,
  input logic        ovf,
  input logic        out_valid
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(ovf));
  assert_clamp32_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && sat_en && sat32 |=> (result[39:31] == '0) || (result[39:31] == '1));
  assert_clamp40_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && sat_en && !sat32 |=> !ovf || result == 40'h7F_FFFF_FFFF || result == 40'h80_0000_0000);
  assert_round_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && rnd_en && !sat_en |=> result[15:0] == 16'h0);
  assert_frac_special_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && frac_en && op_a == 17'h18000 && op_b == 17'h18000 && acc_in == '0
    && !sub_en && !rnd_en |=> result == 40'h00_7FFF_FFFF);
  assert_reset_R1: assert property (@(posedge clk) !rst_n |-> result == '0 && !ovf && !out_valid);
endmodule

bind mac17_lane mac17_lane_chk u_chk (.*);

// File: tb/sim_mac17_lane.sv
module sim_mac17_lane;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, in_valid = 0;
  logic [16:0] op_a = '0, op_b = '0;
  logic [39:0] acc_in = '0;
  logic        frac_en = 0, sub_en = 0, rnd_en = 0, sat_en = 0, sat32 = 0;
  logic [39:0] result;
  logic        ovf, out_valid;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac17_lane u0 (.*);

  function automatic void model(input logic [16:0] a, b, input logic [39:0] acc,
                                input logic fr, sb, rn, st, s32,
                                output logic [39:0] r, output logic o);
    longint p, s, lim;
    p = longint'(signed'(a)) * longint'(signed'(b));
    if (fr) p = (a == 17'h18000 && b == 17'h18000) ? 64'sh7FFF_FFFF : p * 2;
    s = longint'(signed'(acc));
    s = sb ? s - p : s + p;
    if (rn) s = (s + 32768) & ~64'hFFFF;
    lim = s32 ? (64'sd1 <<< 31) : (64'sd1 <<< 39);
    o = (s >= lim) || (s < -lim);
    if (o && st) s = (s < 0) ? -lim : lim - 1;
    r = s[39:0];
  endfunction

  function automatic string tag_of(input logic fr, rn, st, s32, o);
    if (o && st) return s32 ? "R6" : "R7";
    if (o) return "R8";
    if (rn) return "R5";
    if (fr) return "R3";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [39:0] er, input logic eo, input logic ev);
    n_chk++;
    if (result !== er || ovf !== eo || out_valid !== ev) begin
      n_bad++;
      $display("FAIL %s: result=%h ovf=%b vld=%b expected result=%h ovf=%b vld=%b",
               tag, result, ovf, out_valid, er, eo, ev);
    end
  endtask

  task automatic apply(input logic [16:0] a, b, input logic [39:0] acc,
                       input logic fr, sb, rn, st, s32, input string force_tag);
    logic [39:0] er; logic eo;
    op_a = a; op_b = b; acc_in = acc; frac_en = fr; sub_en = sb;
    rnd_en = rn; sat_en = st; sat32 = s32; in_valid = 1;
    model(a, b, acc, fr, sb, rn, st, s32, er, eo);
    @(negedge clk);
    check(force_tag != "" ? force_tag : tag_of(fr, rn, st, s32, eo), er, eo, 1'b1);
  endtask

  task automatic idle();
    logic [39:0] hr; logic ho;
    hr = result; ho = ovf;
    in_valid = 0; op_a = 17'($urandom); op_b = 17'($urandom);
    acc_in = {8'($urandom), 32'($urandom)}; rnd_en = 1; sat_en = 1; sat32 = 1;
    @(negedge clk);
    check("R9", hr, ho, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: result=%h expected completion", result);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [39:0] acc;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", 40'h0, 1'b0, 1'b0);
    rst_n = 1;
    @(negedge clk);
    apply(17'd300, 17'h1FFF9, 40'd1000, 0, 0, 0, 0, 0, "R2");
    apply(17'd300, 17'h1FFF9, 40'd1000, 0, 1, 0, 0, 0, "R2");
    apply(17'h0FFFF, 17'h10000, 40'h0, 0, 0, 0, 0, 0, "R2");
    apply(17'h10000, 17'h10000, 40'h0, 1, 0, 0, 0, 0, "R3");
    apply(17'd1234, 17'd4321, 40'h5, 1, 1, 0, 0, 0, "R3");
    apply(17'h18000, 17'h18000, 40'h0, 1, 0, 0, 0, 0, "R4");
    apply(17'h18000, 17'h18000, 40'h12345, 1, 1, 1, 1, 1, "R4");
    apply(17'd0, 17'd0, 40'h1_7FFF, 0, 0, 1, 0, 0, "R5");
    apply(17'd0, 17'd0, 40'h1_8000, 0, 0, 1, 0, 0, "R5");
    apply(17'd0, 17'd0, 40'h00_7FFF_FFF0, 0, 0, 1, 1, 1, "R6");
    apply(17'd1, 17'd1, 40'h00_7FFF_FFFF, 0, 0, 0, 1, 1, "R6");
    apply(17'd1, 17'd1, 40'hFF_8000_0000, 0, 1, 0, 1, 1, "R6");
    apply(17'd0, 17'd0, 40'h7F_FFFF_FFF0, 0, 0, 1, 1, 0, "R7");
    apply(17'd2, 17'd3, 40'h80_0000_0001, 0, 1, 0, 1, 0, "R7");
    apply(17'd1, 17'd1, 40'h00_7FFF_FFFF, 0, 0, 0, 0, 1, "R8");
    apply(17'd1, 17'd1, 40'h7F_FFFF_FFFF, 0, 0, 0, 0, 0, "R8");
    idle();
    for (int i = 0; i < 4000; i++) begin
      logic [16:0] a, b;
      case ($urandom % 4)
        0: acc = {8'($urandom), 32'($urandom)};
        1: acc = 40'h00_7FFF_0000 + 40'($urandom % 65536) + 40'h0000_8000 * 40'($urandom % 2);
        2: acc = 40'h7F_FFFF_0000 + 40'($urandom % 65536);
        default: acc = 40'hFF_8000_0000 - 40'($urandom % 65536);
      endcase
      a = ($urandom % 8 == 0) ? 17'h18000 : 17'($urandom);
      b = ($urandom % 8 == 0) ? 17'h18000 : 17'($urandom);
      apply(a, b, acc, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "");
      if (i % 7 == 0) idle();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule